// File: doc/BRIEF.md
# ATM Cell Receive Port (8-bit cell bus)

This block takes fixed 53-byte ATM cells from a physical-layer device over an 8-bit byte bus and writes them into an internal FIFO. It can act as the bus master or as the bus slave, and a 2-bit mode code selects the role. On every rising clock edge it samples the data byte, its parity bit and the start-of-cell marker. It also drives or samples the active-low enable line and the cell-available line. Which direction each line takes, and what it means, depends on the role.

Each accepted byte is checked for odd parity and placed inside its cell by a byte counter that the start-of-cell marker re-aligns. On the internal side the consumer sees a byte stream with a valid/ready handshake. Each byte carries a first-byte tag and a last-byte tag. The last byte carries the cell's error flag. The first byte of a cell that cut short an earlier cell carries an abort flag, so the consumer can drop the partial bytes it already took.

Top module: `utopia_rx_port`

## Requirements
- R1: Mode code 2'b01 selects master and 2'b10 selects slave. With 2'b00 or 2'b11 no byte is captured, `rx_enb_no` stays high and `rx_full_o` stays low.
- R2: In master mode `rx_enb_no` is low exactly while the FIFO has at least CELL_BYTES (53) free entries. In every other mode it is high.
- R3: In master mode, the byte on the bus during a cycle is captured only if `rx_enb_no` was low in the previous cycle and `rx_clav_i` is low in this cycle. A high `rx_clav_i` means the PHY has nothing valid.
- R4: In slave mode a byte is captured in any cycle where `rx_enb_ni` is low and the FIFO is not full. `rx_full_o` is high exactly while the FIFO is full. A byte offered while the FIFO is full is lost and does not advance the byte count.
- R5: When the byte count is 0, a captured byte that does not carry `rx_soc_i` is discarded and the count stays at 0.
- R6: Captured bytes leave in arrival order. The byte that carried `rx_soc_i` has `cell_soc_o` set. The 53rd byte of a cell has `cell_eoc_o` set, and the count then returns to 0.
- R7: A byte is in error when the XOR of its 8 data bits and `rx_par_i` is 0, which means odd parity has failed. `cell_err_o` is set on the last byte of a cell if any byte of that cell was in error, and it is 0 on every other byte.
- R8: A start-of-cell byte that arrives while the count is not 0 is written with both `cell_soc_o` and `cell_abort_o` set. The count restarts at byte 1 and the error state is cleared for the new cell.
- R9: `cell_valid_o` is high whenever the FIFO holds a byte. The head byte and its tags stay unchanged until a cycle in which `cell_ready_i` is high.
- R10: While `rst_ni` is low the FIFO is empty, so `cell_valid_o` and `rx_full_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Role code: 01 master, 10 slave, others idle |
| rx_data_i | input | 8 | Received data byte |
| rx_par_i | input | 1 | Odd parity bit for rx_data_i |
| rx_soc_i | input | 1 | Marks byte 0 of a cell |
| rx_clav_i | input | 1 | Master: PHY has no valid data |
| rx_enb_ni | input | 1 | Slave: PHY transfers a byte this cycle (active low) |
| rx_enb_no | output | 1 | Master: ready for a byte next cycle (active low) |
| rx_full_o | output | 1 | Slave: receive FIFO full |
| cell_valid_o | output | 1 | Head byte available |
| cell_ready_i | input | 1 | Consumer takes the head byte |
| cell_data_o | output | 8 | Head byte data |
| cell_soc_o | output | 1 | Head byte is the first byte of a cell |
| cell_eoc_o | output | 1 | Head byte is the last byte of a cell |
| cell_err_o | output | 1 | Cell had a parity error (on last byte) |
| cell_abort_o | output | 1 | Earlier partial cell was cut short (on first byte) |

## Verification
The assertions check several rules on every cycle: the idle modes write nothing, no byte is written while the slave full flag is up, and master writes never reach a full FIFO. They also check that the error flag appears only on last bytes, that the abort flag appears only on first bytes, and that the head entry holds still under backpressure. The bench's scenarios are the only place where these behaviours show up: the one-cycle lead of the master enable, where the 53-byte boundary falls, the discarding of bytes before the first start-of-cell marker, the accumulation of parity errors across a cell, and the loss of bytes offered to a full slave FIFO. A behavioural model checks all of these on every clock.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE0  = 2'b00,
    MODE_MASTER = 2'b01,
    MODE_SLAVE  = 2'b10,
    MODE_IDLE3  = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic       soc;
    logic       eoc;
    logic       err;
    logic       abort;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/utopia_rx_fifo.sv
module utopia_rx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [WIDTH-1:0]               wdata_i,
  input  logic                           pop_i,
  output logic [WIDTH-1:0]               rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH-1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_pop;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop) rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/utopia_rx_hs.sv
module utopia_rx_hs #(
  parameter int DEPTH      = 64,
  parameter int CELL_BYTES = 53
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 mode_i,
  input  logic [$clog2(DEPTH+1)-1:0] count_i,
  input  logic                       clav_i,
  input  logic                       enb_ni,
  output logic                       enb_no,
  output logic                       full_o,
  output logic                       take_o
);
  import utopia_rx_pkg::*;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] ROOM_LIMIT = CW'(DEPTH - CELL_BYTES);
  localparam logic [CW-1:0] FULL_CNT   = CW'(DEPTH);

  logic is_master, is_slave, fifo_full, ready_now, ready_q;

  assign is_master = (rx_mode_e'(mode_i) == MODE_MASTER);
  assign is_slave  = (rx_mode_e'(mode_i) == MODE_SLAVE);
  assign fifo_full = (count_i == FULL_CNT);
  // at least one whole cell of room left
  assign ready_now = is_master && (count_i <= ROOM_LIMIT);
  assign enb_no    = ~ready_now;
  assign full_o    = is_slave && fifo_full;

  // readiness announced one cycle ahead of the transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= ready_now;
  end

  always_comb begin
    take_o = 1'b0;
    if (is_master)     take_o = ready_q && !clav_i;
    else if (is_slave) take_o = !enb_ni && !fifo_full;
  end
endmodule

// File: rtl/utopia_rx_align.sv
module utopia_rx_align #(
  parameter int CELL_BYTES = 53
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      take_i,
  input  logic [7:0]                data_i,
  input  logic                      par_i,
  input  logic                      soc_i,
  output logic                      push_o,
  output utopia_rx_pkg::rx_entry_t  entry_o
);
  localparam int CW = $clog2(CELL_BYTES);
  localparam logic [CW-1:0] LAST_IDX = CW'(CELL_BYTES-1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          par_bad;

  assign par_bad = ~(^{data_i, par_i});

  always_comb begin
    push_o        = 1'b0;
    entry_o       = '0;
    entry_o.data  = data_i;
    cnt_d         = cnt_q;
    err_d         = err_q;
    if (take_i) begin
      if (soc_i) begin
        push_o        = 1'b1;
        entry_o.soc   = 1'b1;
        entry_o.abort = (cnt_q != '0);
        cnt_d         = CW'(1);
        err_d         = par_bad;
      end else if (cnt_q != '0) begin
        push_o = 1'b1;
        if (cnt_q == LAST_IDX) begin
          entry_o.eoc = 1'b1;
          entry_o.err = err_q | par_bad;
          cnt_d       = '0;
          err_d       = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
          err_d = err_q | par_bad;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/utopia_rx_port.sv
module utopia_rx_port #(
  parameter int DEPTH      = 64,
  parameter int CELL_BYTES = 53
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_par_i,
  input  logic       rx_soc_i,
  input  logic       rx_clav_i,
  input  logic       rx_enb_ni,
  output logic       rx_enb_no,
  output logic       rx_full_o,
  output logic       cell_valid_o,
  input  logic       cell_ready_i,
  output logic [7:0] cell_data_o,
  output logic       cell_soc_o,
  output logic       cell_eoc_o,
  output logic       cell_err_o,
  output logic       cell_abort_o
);
  import utopia_rx_pkg::*;
  localparam int CW = $clog2(DEPTH+1);

  logic          take, push;
  logic [CW-1:0] fifo_cnt;
  rx_entry_t     wr_entry, rd_entry;
  logic [ENTRY_W-1:0] rd_raw;

  utopia_rx_hs #(.DEPTH(DEPTH), .CELL_BYTES(CELL_BYTES)) u_hs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .count_i (fifo_cnt),
    .clav_i  (rx_clav_i),
    .enb_ni  (rx_enb_ni),
    .enb_no  (rx_enb_no),
    .full_o  (rx_full_o),
    .take_o  (take)
  );

  utopia_rx_align #(.CELL_BYTES(CELL_BYTES)) u_align (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .data_i  (rx_data_i),
    .par_i   (rx_par_i),
    .soc_i   (rx_soc_i),
    .push_o  (push),
    .entry_o (wr_entry)
  );

  utopia_rx_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wr_entry),
    .pop_i   (cell_ready_i),
    .rdata_o (rd_raw),
    .count_o (fifo_cnt)
  );

  assign rd_entry     = rx_entry_t'(rd_raw);
  assign cell_valid_o = (fifo_cnt != '0);
  assign cell_data_o  = rd_entry.data;
  assign cell_soc_o   = rd_entry.soc;
  assign cell_eoc_o   = rd_entry.eoc;
  assign cell_err_o   = rd_entry.err;
  assign cell_abort_o = rd_entry.abort;
endmodule

// File: rtl/utopia_rx_port_chk.sv
module utopia_rx_port_chk #(
  parameter int DEPTH = 64
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [1:0]                 mode_i,
  input logic                       rx_enb_no,
  input logic                       rx_full_o,
  input logic                       push,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic                       cell_valid_o,
  input logic                       cell_ready_i,
  input logic [7:0]                 cell_data_o,
  input logic                       cell_soc_o,
  input logic                       cell_eoc_o,
  input logic                       cell_err_o,
  input logic                       cell_abort_o
);
  a_r1_idle_mode_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_i == 2'b01 || mode_i == 2'b10) |-> (rx_enb_no && !rx_full_o && !push));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && push) |-> (fifo_cnt < DEPTH));

  a_r4_no_write_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |-> !push);

  a_r6_tags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_valid_o |-> !(cell_soc_o && cell_eoc_o));

  a_r7_err_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && cell_err_o) |-> cell_eoc_o);

  a_r8_abort_on_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && cell_abort_o) |-> cell_soc_o);

  a_r9_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && !cell_ready_i) |=> (cell_valid_o && $stable(cell_data_o)
      && $stable(cell_soc_o) && $stable(cell_eoc_o) && $stable(cell_err_o)));
endmodule

bind utopia_rx_port utopia_rx_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .rx_enb_no    (rx_enb_no),
  .rx_full_o    (rx_full_o),
  .push         (push),
  .fifo_cnt     (fifo_cnt),
  .cell_valid_o (cell_valid_o),
  .cell_ready_i (cell_ready_i),
  .cell_data_o  (cell_data_o),
  .cell_soc_o   (cell_soc_o),
  .cell_eoc_o   (cell_eoc_o),
  .cell_err_o   (cell_err_o),
  .cell_abort_o (cell_abort_o)
);

// File: tb/utopia_rx_port_tb.sv
`timescale 1ns/1ps
module utopia_rx_port_tb;
  localparam int DEPTH = 64;
  localparam int CELL  = 53;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic [7:0] d;
  logic       par, soc, clav, enb_n, ready;
  logic       enb_o, full_o, valid_o, soc_o, eoc_o, err_o, abort_o;
  logic [7:0] data_o;

  always #5 clk = ~clk;

  utopia_rx_port #(.DEPTH(DEPTH), .CELL_BYTES(CELL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .rx_data_i(d), .rx_par_i(par), .rx_soc_i(soc), .rx_clav_i(clav), .rx_enb_ni(enb_n),
    .rx_enb_no(enb_o), .rx_full_o(full_o),
    .cell_valid_o(valid_o), .cell_ready_i(ready), .cell_data_o(data_o),
    .cell_soc_o(soc_o), .cell_eoc_o(eoc_o), .cell_err_o(err_o), .cell_abort_o(abort_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int gap_pct = 0;
  int rdy_pct = 100;
  int seq = 0;

  bit [9:0]  src[$];   // {parity_bad, soc, data}
  bit [11:0] mq[$];    // {soc, eoc, err, abort, data}
  int  m_cnt;
  bit  m_err, m_rdy;
  int  m_sz;
  bit  m_full0, m_rdy_now, m_xfer, m_take, m_bad;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_cnt = 0;
      m_err = 0;
      m_rdy = 0;
    end else begin
      m_sz      = mq.size();
      m_full0   = (m_sz == DEPTH);
      m_rdy_now = (mode == 2'b01) && (DEPTH - m_sz >= CELL);
      m_xfer    = 0;
      m_take    = 0;
      if (mode == 2'b01) begin
        m_xfer = m_rdy && !clav;
        m_take = m_xfer;
      end else if (mode == 2'b10) begin
        m_xfer = !enb_n;
        m_take = m_xfer && !m_full0;
      end
      if (m_sz > 0 && ready) void'(mq.pop_front());
      if (m_take) begin
        m_bad = ((^d) ^ par) == 1'b0;
        if (soc) begin
          mq.push_back({1'b1, 1'b0, 1'b0, (m_cnt != 0), d});
          m_cnt = 1;
          m_err = m_bad;
        end else if (m_cnt != 0) begin
          if (m_cnt == CELL - 1) begin
            mq.push_back({1'b0, 1'b1, (m_err | m_bad), 1'b0, d});
            m_cnt = 0;
            m_err = 0;
          end else begin
            mq.push_back({4'b0000, d});
            m_cnt++;
            m_err = m_err | m_bad;
          end
        end
      end
      if (m_xfer && src.size() > 0) void'(src.pop_front());
      m_rdy = m_rdy_now;
    end
  end

  task automatic compare();
    int  sz = mq.size();
    bit  exp_enb = !((mode == 2'b01) && (DEPTH - sz >= CELL));
    bit  exp_full = (mode == 2'b10) && (sz == DEPTH);
    check(valid_o == (sz > 0), "R9 valid", valid_o, sz > 0);
    check(enb_o == exp_enb, "R2 enable", enb_o, exp_enb);
    check(full_o == exp_full, "R4 full", full_o, exp_full);
    if (sz > 0 && valid_o) begin
      check(data_o == mq[0][7:0], "R3 R5 R6 data", data_o, mq[0][7:0]);
      check(soc_o == mq[0][11], "R6 soc", soc_o, mq[0][11]);
      check(eoc_o == mq[0][10], "R6 eoc", eoc_o, mq[0][10]);
      check(err_o == mq[0][9], "R7 err", err_o, mq[0][9]);
      check(abort_o == mq[0][8], "R8 abort", abort_o, mq[0][8]);
    end
  endtask

  task automatic drive();
    bit avail = src.size() > 0;
    bit gap = ($urandom_range(0, 99) < gap_pct);
    if (avail) begin
      d   = src[0][7:0];
      soc = src[0][8];
      par = src[0][9] ? (^src[0][7:0]) : ~(^src[0][7:0]);
    end else begin
      d   = 8'($urandom);
      soc = 1'b0;
      par = 1'b0;
    end
    clav  = !avail || gap;
    enb_n = !avail || gap;
    ready = ($urandom_range(0, 99) < rdy_pct);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    drive();
  endtask

  task automatic drain(input int extra);
    for (int g = 0; g < 5000 && src.size() > 0; g++) step();
    repeat (extra) step();
  endtask

  task automatic add_cell(input int n, input int bad_at, input bit with_soc);
    for (int i = 0; i < n; i++) begin
      src.push_back({(i == bad_at), (with_soc && i == 0), 8'(seq)});
      seq++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; d = '0; par = 1'b0; soc = 1'b0;
    clav = 1'b1; enb_n = 1'b1; ready = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(valid_o == 1'b0, "R10 valid in reset", valid_o, 0);
    check(full_o == 1'b0, "R10 full in reset", full_o, 0);
    check(enb_o == 1'b1, "R10 R1 enable idle in reset", enb_o, 1);
    rst_n = 1'b1;

    // master, clean cells with PHY gaps (R3 R6)
    mode = 2'b01; gap_pct = 20; rdy_pct = 100;
    repeat (3) add_cell(CELL, -1, 1);
    drain(10);
    // parity errors mid-cell and on the last byte (R7)
    add_cell(CELL, 10, 1);
    add_cell(CELL, CELL - 1, 1);
    add_cell(CELL, -1, 1);
    drain(10);
    // early start-of-cell aborts a partial cell (R8)
    add_cell(20, 5, 1);
    add_cell(CELL, -1, 1);
    drain(10);
    // bytes before any start-of-cell are dropped (R5)
    add_cell(7, -1, 0);
    add_cell(CELL, -1, 1);
    drain(10);
    // backpressure: enable withdrawn once a cell no longer fits (R2)
    rdy_pct = 0; gap_pct = 0;
    repeat (3) add_cell(CELL, -1, 1);
    repeat (150) step();
    check(enb_o == 1'b1, "R2 enable high with FIFO short of room", enb_o, 1);
    rdy_pct = 100;
    drain(20);
    // random consumer and PHY gaps
    rdy_pct = 50; gap_pct = 30;
    repeat (4) add_cell(CELL, ($urandom_range(0, 3) == 0) ? 30 : -1, 1);
    drain(100);

    // slave mode (R4)
    rdy_pct = 100; mode = 2'b10; gap_pct = 25;
    repeat (3) add_cell(CELL, -1, 1);
    drain(10);
    rdy_pct = 70;
    add_cell(CELL, 2, 1);
    drain(100);
    // fill the FIFO: bytes beyond it are lost
    rdy_pct = 0; gap_pct = 0;
    repeat (2) add_cell(CELL, -1, 1);
    drain(5);
    check(full_o == 1'b1, "R4 full flag after overfill", full_o, 1);
    rdy_pct = 100;
    repeat (80) step();
    add_cell(CELL, -1, 1);
    add_cell(CELL, -1, 1);
    drain(80);

    // idle mode codes capture nothing (R1)
    mode = 2'b00; gap_pct = 0;
    add_cell(CELL, -1, 1);
    repeat (30) step();
    check(valid_o == 1'b0, "R1 no capture in mode 00", valid_o, 0);
    check(enb_o == 1'b1 && full_o == 1'b0, "R1 lines idle in mode 00", {enb_o, full_o}, 2);
    mode = 2'b11;
    repeat (30) step();
    check(valid_o == 1'b0, "R1 no capture in mode 11", valid_o, 0);
    src.delete();
    repeat (5) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule